// File: doc/BRIEF.md
# Branch Condition and Redirect Unit

This block sits in the execute stage of a simple in-order core. For each executed instruction it reads the instruction word, the four status flags, the current program counter and the value of the first source register. It decides whether a branch is taken, computes the branch destination, and produces a 0/1 value for a conditional-set instruction. A small sequencer produces the address of the next instruction to execute.

The four-bit condition code is made of a three-bit selector and an invert bit. Together they cover sixteen tests on the zero, negative, overflow and carry flags, both signed and unsigned. The unit handles two kinds of branch. An absolute branch takes a word-aligned destination from the low 25 bits of the word. A register-relative branch adds a scaled, sign-extended offset to the register value.

A taken branch has one delay slot. The instruction that follows the branch in sequence still executes. The sequencer then redirects the program counter once that slot instruction has executed. The register file and instruction fetch are outside this block.

Top module: `cond_branch_unit`

## Requirements
- R1: The condition code is `{instr[27:25], instr[0]}`. Its flag input is `flags = {Z,N,V,C}` in bits 3..0. The codes 0000 to 0111 test, in order: always true, never true, C and not Z, not C or Z, not C, C, not Z, Z.
- R2: The codes 1000 to 1111 test, in order: not V, V, not N, N, N equal to V, N different from V, not Z and N equal to V, Z or N different from V.
- R3: Only a word with `instr[31:28] = 1110` belongs to the branch family. Any other word gives `taken = 0` and `set_en = 0`.
- R4: A branch-family word with `instr[1] = 0` is an absolute branch. Its `target` is `instr[24:2]` followed by two zero bits, zero-extended, so it lies in the range 0 to 2^25-4. `taken` is 1 when the instruction is valid and the condition holds.
- R5: A branch-family word with `instr[1] = 1` and `instr[24] = 1` is a relative branch. Its `target` is `rs1_val` plus 4 times the sign-extended 14-bit field `instr[15:2]`, wrapping modulo 2^32.
- R6: A branch-family word with `instr[1] = 1` and `instr[24] = 0` is a conditional set. It gives `set_en = 1`, `set_dst = instr[22:18]`, `set_val` equal to 1 or 0 as the condition holds, and `taken = 0`.
- R7: When no redirect is pending, `next_pc = pc + 4`. This covers every instruction after a branch that is not taken.
- R8: After a valid taken branch, the next valid instruction (the delay slot) still gets `next_pc = pc + 4` computed for the branch. The slot instruction itself gets `next_pc` equal to the branch target. The instruction after the slot runs sequentially again.
- R9: A taken branch that sits in a delay slot follows the same one-slot rule. The slot instruction gets the first target as its `next_pc`. The instruction at the first target then gets the second target as its `next_pc`.
- R10: A cycle with `instr_valid = 0` gives `taken = 0` and `set_en = 0`. In such a cycle a pending redirect is neither consumed nor changed, so `next_pc` keeps showing the pending target.
- R11: Synchronous active-high reset clears any pending redirect, so the first instruction after reset gets `next_pc = pc + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | Status flags {Z,N,V,C} |
| pc | input | 32 | Address of the executing instruction |
| rs1_val | input | 32 | First source register value |
| taken | output | 1 | Branch taken this cycle |
| target | output | 32 | Branch destination (0 for words that are not branches) |
| next_pc | output | 32 | Address of the next instruction to execute |
| set_en | output | 1 | Conditional-set write enable |
| set_dst | output | 5 | Conditional-set destination register index |
| set_val | output | 32 | Conditional-set result, 0 or 1 |

## Verification
The assertions assume that reset is held during the first clock edges, before any instruction is presented. They also assume that the inputs change only between edges, so that `pc` and `instr_valid` in the cycle after a branch describe the slot instruction. The stimulus drives every input on the falling edge and always starts with a reset. It builds words by form (absolute, relative, conditional set, other opcode, raw random), so that each condition code meets all sixteen flag patterns. Idle cycles are mixed in between pending redirects and their slot instructions.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    localparam logic [3:0] OPC_BRANCH = 4'b1110;
    localparam int unsigned DST_W      = 5;
    localparam int unsigned OFF_W      = 14;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_ABS  = 2'd1,
        KIND_REL  = 2'd2,
        KIND_SET  = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } cc_flags_t;

    typedef struct packed {
        br_kind_e         kind;
        logic [2:0]       sel;
        logic             inv;
        logic [DST_W-1:0] dst;
    } br_decode_t;

    // Base test for a selector; the invert bit flips it afterwards.
    function automatic logic cond_base(logic [2:0] sel, cc_flags_t f);
        logic sv_eq;
        sv_eq = (f.n == f.v);
        unique case (sel)
            3'd0: cond_base = 1'b1;
            3'd1: cond_base = f.c & ~f.z;
            3'd2: cond_base = ~f.c;
            3'd3: cond_base = ~f.z;
            3'd4: cond_base = ~f.v;
            3'd5: cond_base = ~f.n;
            3'd6: cond_base = sv_eq;
            default: cond_base = sv_eq & ~f.z;
        endcase
    endfunction

endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
    import cbu_pkg::*;
(
    input  logic [3:0]       opc,
    input  logic [2:0]       sel,
    input  logic             form_hi,
    input  logic             form_lo,
    input  logic             inv,
    input  logic [DST_W-1:0] dst,
    output br_decode_t       dec
);
    always_comb begin
        dec.sel = sel;
        dec.inv = inv;
        dec.dst = dst;
        if (opc != OPC_BRANCH)
            dec.kind = KIND_NONE;
        else if (!form_lo)
            dec.kind = KIND_ABS;
        else if (form_hi)
            dec.kind = KIND_REL;
        else
            dec.kind = KIND_SET;
    end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       inv,
    input  cc_flags_t  fl,
    output logic       cond_true
);
    logic base;

    always_comb begin
        base      = cond_base(sel, fl);
        cond_true = base ^ inv;
    end
endmodule

// File: rtl/cbu_target_gen.sv
module cbu_target_gen
    import cbu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ABS_W  = 25
) (
    input  br_kind_e            kind,
    input  logic [ABS_W-3:0]    abs_field,
    input  logic [OFF_W-1:0]    off_field,
    input  logic [DATA_W-1:0]   base_reg,
    output logic [DATA_W-1:0]   tgt
);
    localparam int unsigned ABS_PAD = DATA_W - ABS_W;
    localparam int unsigned OFF_PAD = DATA_W - OFF_W - 2;

    logic [DATA_W-1:0] abs_tgt;
    logic [DATA_W-1:0] rel_off;
    logic [DATA_W-1:0] rel_tgt;

    always_comb begin
        abs_tgt = {{ABS_PAD{1'b0}}, abs_field, 2'b00};
        rel_off = {{OFF_PAD{off_field[OFF_W-1]}}, off_field, 2'b00};
        rel_tgt = base_reg + rel_off;
        unique case (kind)
            KIND_ABS: tgt = abs_tgt;
            KIND_REL: tgt = rel_tgt;
            default:  tgt = '0;
        endcase
    end
endmodule

// File: rtl/cbu_redirect_seq.sv
module cbu_redirect_seq #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              take,
    input  logic [DATA_W-1:0] tgt,
    input  logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] next_pc
);
    localparam logic [DATA_W-1:0] PC_INC = DATA_W'(4);

    logic              pend_q;
    logic [DATA_W-1:0] pend_tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_tgt_q <= '0;
        end else if (step) begin
            pend_q     <= take;
            pend_tgt_q <= tgt;
        end
    end

    always_comb begin
        next_pc = pend_q ? pend_tgt_q : (pc + PC_INC);
    end

    // R8: the instruction after a taken branch is sent to its target
    assert_slot_redirect_R8: assert property (@(posedge clk) disable iff (rst)
        (step && take) |=> (next_pc == $past(tgt)));

    // R7: after an instruction that sets no redirect, flow is sequential
    assert_sequential_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !take) |=> (next_pc == pc + PC_INC));

    // R10: idle cycles leave the redirect state alone
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!step) |=> ($stable(pend_q) && $stable(pend_tgt_q)));

    // R11: reset leaves no redirect pending
    assert_reset_clear_R11: assert property (@(posedge clk)
        $past(rst) |-> (next_pc == pc + PC_INC));
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
    import cbu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ABS_W  = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    input  logic [3:0]        flags,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] rs1_val,
    output logic              taken,
    output logic [DATA_W-1:0] target,
    output logic [DATA_W-1:0] next_pc,
    output logic              set_en,
    output logic [4:0]        set_dst,
    output logic [DATA_W-1:0] set_val
);
    br_decode_t dec;
    cc_flags_t  fl;
    logic       cond_true;
    logic       is_jump;
    logic       unused_bits;

    assign fl          = cc_flags_t'(flags);
    assign unused_bits = ^{instr[23], instr[17:16]};

    cbu_decode u_decode (
        .opc     (instr[31:28]),
        .sel     (instr[27:25]),
        .form_hi (instr[24]),
        .form_lo (instr[1]),
        .inv     (instr[0]),
        .dst     (instr[22:18]),
        .dec     (dec)
    );

    cbu_cond_eval u_cond (
        .sel       (dec.sel),
        .inv       (dec.inv),
        .fl        (fl),
        .cond_true (cond_true)
    );

    cbu_target_gen #(
        .DATA_W (DATA_W),
        .ABS_W  (ABS_W)
    ) u_tgt (
        .kind      (dec.kind),
        .abs_field (instr[ABS_W-1:2]),
        .off_field (instr[OFF_W+1:2]),
        .base_reg  (rs1_val),
        .tgt       (target)
    );

    always_comb begin
        is_jump = (dec.kind == KIND_ABS) || (dec.kind == KIND_REL);
        taken   = instr_valid && is_jump && cond_true;
        set_en  = instr_valid && (dec.kind == KIND_SET);
        set_dst = dec.dst;
        set_val = {{(DATA_W-1){1'b0}}, cond_true};
    end

    cbu_redirect_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .step    (instr_valid),
        .take    (taken),
        .tgt     (target),
        .pc      (pc),
        .next_pc (next_pc)
    );

    // R6: a conditional set never branches
    assert_set_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(taken && set_en));

    // R4: absolute destinations are word aligned and inside the window
    assert_abs_range_R4: assert property (@(posedge clk) disable iff (rst)
        (taken && !instr[1]) |->
            (target[1:0] == 2'b00 && target[DATA_W-1:ABS_W] == '0));

    // R1: code 0001 never branches and never sets
    assert_never_code_R1: assert property (@(posedge clk) disable iff (rst)
        (instr[31:28] == OPC_BRANCH && {instr[27:25], instr[0]} == 4'b0001)
            |-> (!taken && set_val[0] == 1'b0));

    // R3: words outside the branch family stay inert
    assert_other_opc_R3: assert property (@(posedge clk) disable iff (rst)
        (instr[31:28] != OPC_BRANCH) |-> (!taken && !set_en));

    // R10: an idle cycle neither branches nor sets
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!taken && !set_en));
endmodule

// File: tb/cond_branch_unit_test.sv
`timescale 1ns/1ps
module cond_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [3:0]  flags = 4'h0;
    logic [31:0] pc = 32'h0;
    logic [31:0] rs1_val = 32'h0;
    logic        taken;
    logic [31:0] target;
    logic [31:0] next_pc;
    logic        set_en;
    logic [4:0]  set_dst;
    logic [31:0] set_val;

    int n_chk  = 0;
    int n_fail = 0;

    // model state
    bit          m_pend  = 1'b0;
    logic [31:0] m_tgt   = 32'h0;
    bit          m_chain = 1'b0;
    bit          m_gap   = 1'b0;

    always #4 clk = ~clk;

    cond_branch_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .flags(flags), .pc(pc), .rs1_val(rs1_val), .taken(taken),
        .target(target), .next_pc(next_pc), .set_en(set_en),
        .set_dst(set_dst), .set_val(set_val)
    );

    function automatic bit exp_cond(logic [3:0] code, logic [3:0] f);
        bit z, n, v, c;
        z = f[3]; n = f[2]; v = f[1]; c = f[0];
        case (code)
            4'h0: return 1'b1;
            4'h1: return 1'b0;
            4'h2: return c && !z;
            4'h3: return !c || z;
            4'h4: return !c;
            4'h5: return c;
            4'h6: return !z;
            4'h7: return z;
            4'h8: return !v;
            4'h9: return v;
            4'hA: return !n;
            4'hB: return n;
            4'hC: return n == v;
            4'hD: return n != v;
            4'hE: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    // 0 other, 1 absolute, 2 relative, 3 conditional set
    function automatic int exp_kind(logic [31:0] w);
        if (w[31:28] != 4'hE) return 0;
        if (!w[1]) return 1;
        if (w[24]) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] exp_target(logic [31:0] w, logic [31:0] r);
        int k;
        logic [31:0] off;
        k = exp_kind(w);
        if (k == 1) return {7'd0, w[24:2], 2'b00};
        if (k == 2) begin
            off = {{16{w[15]}}, w[15:2], 2'b00};
            return r + off;
        end
        return 32'h0;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pend = 1'b0;
        m_chain = 1'b0;
        m_gap = 1'b0;
    endtask

    task automatic drive(bit v, logic [31:0] w, logic [3:0] f,
                         logic [31:0] p, logic [31:0] r);
        int          k;
        bit          cnd, e_taken, e_set;
        logic [31:0] e_tgt, e_next;
        string       tag;
        @(negedge clk);
        instr_valid = v; instr = w; flags = f; pc = p; rs1_val = r;
        #1;
        k       = exp_kind(w);
        cnd     = exp_cond({w[27:25], w[0]}, f);
        e_taken = v && (k == 1 || k == 2) && cnd;
        e_set   = v && (k == 3);
        e_tgt   = exp_target(w, r);
        e_next  = m_pend ? m_tgt : p + 32'd4;

        if (!v) tag = "R10";
        else if (k == 0) tag = "R3";
        else if (k == 3) tag = "R6";
        else tag = w[27] ? "R2" : "R1";
        chk(taken == e_taken, tag, {31'd0, taken}, {31'd0, e_taken});
        chk(set_en == e_set, (k == 3 || !v) ? tag : "R3", {31'd0, set_en}, {31'd0, e_set});

        if (k == 1) chk(target == e_tgt, "R4", target, e_tgt);
        if (k == 2) chk(target == e_tgt, "R5", target, e_tgt);
        if (e_set) begin
            chk(set_dst == w[22:18], "R6", {27'd0, set_dst}, {27'd0, w[22:18]});
            chk(set_val == {31'd0, cnd}, w[27] ? "R2" : "R1", set_val, {31'd0, cnd});
        end

        if (!m_pend) tag = "R7";
        else if (m_gap) tag = "R10";
        else if (m_chain) tag = "R9";
        else tag = "R8";
        chk(next_pc == e_next, tag, next_pc, e_next);

        if (v) begin
            m_chain = e_taken && m_pend;
            m_pend  = e_taken;
            m_tgt   = e_tgt;
            m_gap   = 1'b0;
        end else begin
            m_gap = 1'b1;
        end
    endtask

    function automatic logic [31:0] mk_abs(logic [3:0] code, logic [22:0] word_addr);
        return {4'hE, code[3:1], word_addr, 1'b0, code[0]};
    endfunction

    function automatic logic [31:0] mk_rel(logic [3:0] code, logic [13:0] off);
        return {4'hE, code[3:1], 1'b1, 1'b0, 5'd0, 2'b00, off, 1'b1, code[0]};
    endfunction

    function automatic logic [31:0] mk_set(logic [3:0] code, logic [4:0] dst);
        return {4'hE, code[3:1], 1'b0, 1'b0, dst, 16'd0, 1'b1, code[0]};
    endfunction

    localparam logic [31:0] NOP = 32'h0000_0000;

    initial begin : watchdog
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        do_reset();

        // R11: reset state, sequential flow
        drive(1, NOP, 4'h0, 32'h100, 32'h0);

        // R1 / R2: every code against every flag pattern (never-taken codes keep flow sequential)
        for (int cd = 0; cd < 16; cd++) begin
            for (int fp = 0; fp < 16; fp++) begin
                drive(1, mk_set(4'(cd), 5'(cd + fp)), 4'(fp), 32'h2000, 32'h0);
                drive(1, mk_abs(4'(cd), 23'h400 + 23'(cd)), 4'(fp), 32'h3000, 32'h0);
            end
        end
        drive(1, NOP, 4'h0, 32'h40, 32'h0);
        drive(1, NOP, 4'h0, 32'h44, 32'h0);

        // R4: top of the absolute window
        drive(1, 32'hE1FF_FFFC, 4'h0, 32'h500, 32'h0);
        drive(1, NOP, 4'h0, 32'h504, 32'h0);
        drive(1, NOP, 4'h0, 32'h01FF_FFFC, 32'h0);

        // R5: negative offset and wrap below zero
        drive(1, mk_rel(4'h0, 14'h3FFF), 4'h0, 32'h600, 32'h10);
        drive(1, NOP, 4'h0, 32'h604, 32'h0);
        drive(1, mk_rel(4'h0, 14'h3FFF), 4'h0, 32'hC, 32'h0);
        drive(1, NOP, 4'h0, 32'h10, 32'h0);
        drive(1, mk_rel(4'h0, 14'h1FFF), 4'h0, 32'hFFFF_FFFC, 32'hFFFF_FFF0);
        drive(1, NOP, 4'h0, 32'h0, 32'h0);

        // R8: plain delay slot
        drive(1, mk_abs(4'h0, 23'h400), 4'h0, 32'h200, 32'h0);
        drive(1, NOP, 4'h0, 32'h204, 32'h0);
        drive(1, NOP, 4'h0, 32'h1000, 32'h0);

        // R9: taken branch inside a delay slot
        drive(1, mk_abs(4'h0, 23'h100), 4'h0, 32'h300, 32'h0);
        drive(1, mk_abs(4'h7, 23'h140), 4'h8, 32'h304, 32'h0);
        drive(1, NOP, 4'h0, 32'h400, 32'h0);
        drive(1, NOP, 4'h0, 32'h500, 32'h0);

        // R10: idle cycles hold the pending redirect
        drive(1, mk_rel(4'h5, 14'h0010), 4'h1, 32'h700, 32'h800);
        drive(0, mk_abs(4'h0, 23'h7), 4'h0, 32'h704, 32'h0);
        drive(0, NOP, 4'h0, 32'h704, 32'h0);
        drive(0, mk_set(4'h0, 5'd3), 4'h0, 32'h704, 32'h0);
        drive(1, NOP, 4'h0, 32'h704, 32'h0);
        drive(1, NOP, 4'h0, 32'h840, 32'h0);

        // R11: reset drops a pending redirect
        drive(1, mk_abs(4'h0, 23'h55), 4'h0, 32'h900, 32'h0);
        do_reset();
        drive(1, NOP, 4'h0, 32'h904, 32'h0);

        // R3: branch-like fields under a different opcode
        drive(1, 32'hD1FF_FFFC, 4'h0, 32'hA00, 32'h0);
        drive(1, 32'hF000_0002, 4'h0, 32'hA04, 32'h0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int          sel;
            logic [31:0] w;
            logic [3:0]  cd;
            bit          v;
            cd  = 4'($urandom);
            sel = int'($urandom % 5);
            case (sel)
                0: begin
                    w = $urandom;
                    if (w[31:28] == 4'hE) w[31:28] = 4'h6;
                end
                1: w = mk_abs(cd, 23'($urandom));
                2: w = mk_rel(cd, 14'($urandom));
                3: w = mk_set(cd, 5'($urandom));
                default: w = $urandom;
            endcase
            v = ($urandom % 10) != 0;
            if (($urandom % 200) == 0) do_reset();
            drive(v, w, 4'($urandom), {$urandom, 2'b00} & 32'hFFFF_FFFC, $urandom);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule